// File: doc/BRIEF.md
# Acknowledge-Clocked Serial Digit Shifter

This block sits between a tone decoder and a single serial output pin. A steering flag from the decoder shows that a 4-bit digit is ready. An external controller then sends acknowledge pulses, and the block shifts the digit out on the pin one bit per pulse, least significant bit first. The digit is captured on the first acknowledge rising edge, not when the steering flag rises. A sequence that has been started must be finished before a new digit can be taken.

When no shift is running, the same pin carries an energy-present (cadence) flag, so the block acts as a two-source multiplexer on one pin. A power-down input forces the pin low and abandons any sequence in progress.

The acknowledge input is asynchronous and is brought into the system clock domain before its edges are used. The steering flag, the digit and the energy flag are synchronous to the system clock. None of the interfaces carries valid/ready handshaking. Each input is a plain level or strobe, and there is no back-pressure: the controller that drives the acknowledge pulses sets the pace alone.

Top module: `ack_digit_shifter`

## Requirements
- R1: After reset, with power-down low, the sequencer is idle, the pin equals `energy_i`, and acknowledge pulses are ignored until a steering rising edge arrives.
- R2: Once a steering rising edge has armed the block, the first acknowledge rising edge captures `digit_i` and puts bit 0 on the pin. The bit appears 3 system clock cycles after `ack_i` rises (two synchroniser flops plus the edge-detect flop).
- R3: Each of the next three acknowledge rising edges moves the pin to the next captured bit, in the order bit 1, bit 2, bit 3.
- R4: Changes on `digit_i` after the capture have no effect on the bits that are shifted out.
- R5: The pin shows the shifted bit from the first acknowledge rising edge up to the fourth acknowledge falling edge, whatever the value of `energy_i`. Outside that interval it shows `energy_i`.
- R6: If a steering rising edge arrives while a sequence is incomplete, no new digit is captured. The remaining pulses still shift the old digit, and once that digit is finished the block is not armed.
- R7: Acknowledge pulses after the fourth are ignored, and the pin keeps showing `energy_i`, until the next steering rising edge.
- R8: Acknowledge pulses that arrive while the block is not armed have no effect.
- R9: While `pwdn_i` is high the pin is low, whatever `energy_i` is. Power-down discards any sequence and any pending arm, so a steering rising edge is needed after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digit_i | input | 4 | Decoded digit, sampled at the first acknowledge edge |
| steer_i | input | 1 | Steering flag; its rising edge arms the shifter |
| ack_i | input | 1 | Asynchronous acknowledge pulses, idle low |
| energy_i | input | 1 | Energy-present (cadence) flag |
| pwdn_i | input | 1 | Power-down; forces the pin low |
| sdo_o | output | 1 | Serial data / cadence output pin |

## Verification
The hardest state to reach from the ports is a steering rising edge that lands in the middle of an unfinished sequence while a different digit sits on `digit_i`. Only the rules in R6 then decide what the next pulses produce. The stimulus reaches this state with a directed sequence: it sends two pulses for one digit, raises the steering flag again with a new digit, finishes the old digit, and then shows that a further pulse yields the cadence flag rather than new data. Random digits and a random `energy_i` that toggles while each bit is held show that the mux selection does not depend on the cadence flag.

// File: rtl/ackser_pkg.sv
package ackser_pkg;
  // Which source drives the serial pin
  typedef enum logic [1:0] {
    SRC_ENERGY = 2'd0,
    SRC_DATA   = 2'd1,
    SRC_OFF    = 2'd2
  } sd_src_e;
endpackage

// File: rtl/ackser_sync.sv
module ackser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchroniser flops followed by one history flop for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_i};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
  assign fall_o = ~chain[STAGES-1] & chain[STAGES];

  // R2: a detected rise cannot repeat on the very next cycle
  a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ackser_seq.sv
module ackser_seq #(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwdn_i,
  input  logic               steer_i,
  input  logic               ack_rise_i,
  input  logic               ack_fall_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic               busy_o,
  output logic               bit_o
);
  localparam int CNT_W = $clog2(DIGIT_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIGIT_W);

  logic               steer_q;
  logic               armed;
  logic [CNT_W-1:0]   cnt;     // 0 idle, 1..DIGIT_W pulses seen
  logic [DIGIT_W-1:0] shreg;
  logic               steer_rise;

  assign steer_rise = steer_i & ~steer_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      steer_q <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
    end else if (pwdn_i) begin
      steer_q <= steer_i;
      armed   <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
    end else begin
      steer_q <= steer_i;
      if (cnt == '0) begin
        if (armed && ack_rise_i) begin
          shreg <= digit_i;
          cnt   <= CNT_W'(1);
        end else if (steer_rise) begin
          armed <= 1'b1;
        end
      end else begin
        // steering edges are ignored while a sequence is open
        if (ack_rise_i && cnt != LAST) begin
          shreg <= shreg >> 1;
          cnt   <= cnt + 1'b1;
        end else if (ack_fall_i && cnt == LAST) begin
          cnt   <= '0;
          armed <= 1'b0;
        end
      end
    end
  end

  assign busy_o = (cnt != '0);
  assign bit_o  = shreg[0];

  a_r2_capture_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwdn_i && cnt == '0 && armed && ack_rise_i) |=> (busy_o && bit_o == $past(digit_i[0])));

  a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  a_r8_unarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwdn_i && !armed && cnt == '0 && ack_rise_i) |=> !busy_o);

  a_r9_pwdn_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwdn_i |=> (!busy_o && !armed));

  a_r6_busy_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> armed);
endmodule

// File: rtl/ackser_mux.sv
module ackser_mux
  import ackser_pkg::*;
(
  input  logic pwdn_i,
  input  logic busy_i,
  input  logic data_bit_i,
  input  logic energy_i,
  output logic sd_o
);
  sd_src_e src;

  always_comb begin
    if (pwdn_i)      src = SRC_OFF;
    else if (busy_i) src = SRC_DATA;
    else             src = SRC_ENERGY;
  end

  always_comb begin
    case (src)
      SRC_DATA:   sd_o = data_bit_i;
      SRC_ENERGY: sd_o = energy_i;
      default:    sd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ack_digit_shifter.sv
module ack_digit_shifter #(
  parameter int DIGIT_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               steer_i,
  input  logic               ack_i,
  input  logic               energy_i,
  input  logic               pwdn_i,
  output logic               sdo_o
);
  logic ack_rise, ack_fall, busy, data_bit;

  ackser_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ack_i),
    .rise_o  (ack_rise),
    .fall_o  (ack_fall)
  );

  ackser_seq #(.DIGIT_W(DIGIT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwdn_i     (pwdn_i),
    .steer_i    (steer_i),
    .ack_rise_i (ack_rise),
    .ack_fall_i (ack_fall),
    .digit_i    (digit_i),
    .busy_o     (busy),
    .bit_o      (data_bit)
  );

  ackser_mux u_mux (
    .pwdn_i     (pwdn_i),
    .busy_i     (busy),
    .data_bit_i (data_bit),
    .energy_i   (energy_i),
    .sd_o       (sdo_o)
  );

  // R5: a sequence only opens on a synchronised acknowledge rise
  a_r5_open_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && busy) |-> $past(ack_rise));
endmodule

// File: tb/ack_digit_shifter_test.sv
module ack_digit_shifter_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] digit_i = '0;
  logic       steer_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       energy_i = 1'b0;
  logic       pwdn_i = 1'b0;
  logic       sdo_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ack_digit_shifter uut (
    .clk(clk), .rst_n(rst_n), .digit_i(digit_i), .steer_i(steer_i),
    .ack_i(ack_i), .energy_i(energy_i), .pwdn_i(pwdn_i), .sdo_o(sdo_o)
  );

  function automatic logic exp_bit(input logic [3:0] d, input int idx);
    return d[idx];
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic steer_edge(input logic [3:0] d);
    steer_i = 1'b0; digit_i = d; wait_cyc(2);
    steer_i = 1'b1; wait_cyc(2);
  endtask

  task automatic ack_high(); ack_i = 1'b1; wait_cyc(4); endtask
  task automatic ack_low();  ack_i = 1'b0; wait_cyc(4); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [3:0] d, d2;
    void'($urandom(32'h5eed_0042));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1: reset state, pin follows energy
    energy_i = 1'b1; wait_cyc(1); check("R1 energy hi", sdo_o, 1'b1);
    energy_i = 1'b0; wait_cyc(1); check("R1 energy lo", sdo_o, 1'b0);
    // R1/R8: pulse without any arm is ignored
    energy_i = 1'b1; ack_high(); check("R8 unarmed pulse", sdo_o, 1'b1);
    ack_low();

    // R2: latency exactly 3 cycles from ack rise
    steer_edge(4'b1010);
    energy_i = 1'b1;
    ack_i = 1'b1; wait_cyc(2); check("R2 before latency", sdo_o, 1'b1);
    wait_cyc(1); check("R2 bit0 at 3 cycles", sdo_o, 1'b0);
    wait_cyc(1); ack_low();
    for (int i = 1; i < 4; i++) begin
      ack_high(); check("R3 directed bit", sdo_o, exp_bit(4'b1010, i));
      ack_low();
    end
    check("R5 after fourth fall", sdo_o, 1'b1);
    ack_high(); check("R7 extra pulse", sdo_o, 1'b1); ack_low();

    // Random sequences
    for (int it = 0; it < 24; it++) begin
      d = 4'($urandom);
      steer_edge(d);
      for (int i = 0; i < 4; i++) begin
        ack_high();
        energy_i = 1'($urandom); digit_i = 4'($urandom); // R4 and R5 disturbances
        wait_cyc(1);
        check("R3 random bit", sdo_o, exp_bit(d, i));
        energy_i = ~energy_i; wait_cyc(1);
        check("R5 energy ignored while busy", sdo_o, exp_bit(d, i));
        ack_low();
      end
      energy_i = 1'($urandom); wait_cyc(1);
      check("R5 energy restored", sdo_o, energy_i);
      if (it % 4 == 0) begin
        ack_high(); check("R7 random extra", sdo_o, energy_i); ack_low();
      end
    end

    // R6: steering edge during an incomplete sequence
    d = 4'b0110; d2 = 4'b1001;
    energy_i = 1'b0;
    steer_edge(d);
    ack_high(); check("R6 old b0", sdo_o, exp_bit(d, 0)); ack_low();
    ack_high(); check("R6 old b1", sdo_o, exp_bit(d, 1)); ack_low();
    steer_edge(d2);
    ack_high(); check("R6 old b2 kept", sdo_o, exp_bit(d, 2)); ack_low();
    ack_high(); check("R6 old b3 kept", sdo_o, exp_bit(d, 3)); ack_low();
    energy_i = 1'b1;
    ack_high(); check("R6 not re-armed", sdo_o, 1'b1); ack_low();
    steer_edge(d2);
    ack_high(); check("R6 new digit b0", sdo_o, exp_bit(d2, 0)); ack_low();
    for (int i = 1; i < 4; i++) begin ack_high(); ack_low(); end

    // R9: power-down
    steer_edge(4'b1111);
    energy_i = 1'b1;
    ack_high(); check("R9 pre b0", sdo_o, 1'b1); ack_low();
    energy_i = 1'b0; wait_cyc(1);
    check("R9 busy shows data", sdo_o, 1'b1);
    pwdn_i = 1'b1; energy_i = 1'b1; wait_cyc(1);
    check("R9 pin low in pwdn", sdo_o, 1'b0);
    wait_cyc(3);
    pwdn_i = 1'b0; energy_i = 1'b0; wait_cyc(1);
    check("R9 sequence dropped", sdo_o, 1'b0);
    ack_high(); check("R9 needs new arm", sdo_o, 1'b0); ack_low();
    steer_edge(4'b0001);
    ack_high(); check("R9 rearmed b0", sdo_o, 1'b1); ack_low();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule